// File: doc/BRIEF.md
# Recursive Sine/Cosine Twiddle Oscillator

This block produces a stream of sine and cosine samples of nθ for FFT twiddle factors without a full-circle coefficient ROM. Each new sample comes from the second-order difference equation x(n) = 2cosθ·x(n−1) − x(n−2), with the sine and cosine each running their own recurrence. A recurrence like this drifts as rounding error builds up. To stop the drift, every new result has its three low-order bits forced back to those of the exactly rounded value. The exact bits come from a small table that holds three bits per phase position.

A controller picks an angle step with a small code and pulses `start`. It then pulses `step` once for each twiddle factor it needs. Each step gives one new sine/cosine pair, which is flagged by `valid` in the next cycle. The sine path is kept at 16 bits. The cosine path is kept at 23 bits, where 1.0 is 0x200000, and is rounded to 16 bits at the output.

Top module: `twiddle_osc`

## Requirements
- R1: After reset, valid is 0, sin_out is 0 and cos_out is 0. The internal state equals that loaded by a start with angle code 0.
- R2: A start with angle code s selects θ = 2π·2^s / 2^LOG2_N and sets the sample index n back to 0. The start cycle raises no valid and leaves both outputs unchanged. The first step after a start delivers n = 1.
- R3: valid is 1 in exactly those cycles that follow a cycle with step = 1 and start = 0. It is 0 in every other cycle.
- R4: On each valid, sin_out, read as a two's-complement value, equals floor(32767·sin(nθ) + 0.5).
- R5: On each valid, cos_out equals floor((C + 32) / 64), where C = floor(2^21·cos(nθ) + 0.5). The result is clamped to [−32768, 32767]. So cos = 1.0 gives 32767 and cos = −1.0 gives −32768.
- R6: R4 and R5 hold exactly after any number of steps, including steps past one or many full turns of the circle. This works because the 3 low bits of every new internal sample are replaced by those of the exact value, which corrects a raw error in the window [−3, +4] LSB.
- R7: When start and step are high in the same cycle, the start takes effect and the step is dropped, with no valid in the next cycle.
- R8: In a cycle without an accepted step, sin_out and cos_out keep their values.
- R9: Steps issued after reset without any start run with angle code 0 (θ = 2π/2^LOG2_N).
- R10: An angle code above LOG2_N−1 acts as LOG2_N−1, which gives θ = π.
- R11: A start issued in the middle of a sequence drops the previous history. The next step gives n = 1 of the new angle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load the initial conditions for angle_sel and set n back to 0 |
| angle_sel | input | $clog2(LOG2_N) | Angle step code s, θ = 2π·2^s/2^LOG2_N |
| step | input | 1 | Produce the next sample pair |
| sin_out | output | SIN_W | sin(nθ), 32767 full scale |
| cos_out | output | OUT_W | cos(nθ) rounded to 16 bits, 32767 full scale |
| valid | output | 1 | A new pair is present on the outputs |

## Verification
The bench builds the block with its default parameters: LOG2_N = 6 (64 phase positions), a 16-bit sine, a 23-bit cosine and 24 coefficient fraction bits. With these values, angle codes 0 to 5 cover every step size from 2π/64 to π, and codes 6 and 7 exercise the clamp to π. The coarsest step reaches cos = −1 on its first sample and cos = +1 on its second, which tests both ends of the saturation. The finest step, run for 1500 samples, wraps the phase more than twenty times, which is enough for any drift to show.

// File: rtl/twg_pkg.sv
package twg_pkg;

    localparam real TWG_PI = 3.14159265358979323846;
    localparam int  CORR_W = 3;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_ADV  = 2'd1,
        OP_LOAD = 2'd2
    } twg_op_e;

    // Exactly rounded amp*sin or amp*cos of 2*pi*phase/2^log2n, floor(v+0.5).
    function automatic int q_wave(input int phase, input int log2n,
                                  input real amp, input bit use_cos);
        real ang;
        real v;
        ang = 2.0 * TWG_PI * real'(phase) / real'(1 << log2n);
        v   = use_cos ? $cos(ang) : $sin(ang);
        return $rtoi($floor(amp * v + 0.5));
    endfunction

    // Angle codes past the last legal one behave as the last one.
    function automatic int clamp_sel(input int s, input int log2n);
        return (s > log2n - 1) ? log2n - 1 : s;
    endfunction

endpackage

// File: rtl/twg_rom.sv
module twg_rom #(
    parameter int LOG2_N    = 6,
    parameter int SIN_W     = 16,
    parameter int COS_W     = 23,
    parameter int COEF_FRAC = 24
) (
    input  logic [$clog2(LOG2_N)-1:0]        load_sel,
    input  logic [$clog2(LOG2_N)-1:0]        run_sel,
    input  logic [LOG2_N-1:0]                lsb_idx,
    output logic signed [COEF_FRAC+1:0]      coef,
    output logic signed [SIN_W-1:0]          sin_init,
    output logic signed [COS_W-1:0]          cos_init,
    output logic [twg_pkg::CORR_W-1:0]       sin_lsb,
    output logic [twg_pkg::CORR_W-1:0]       cos_lsb
);
    localparam int  NPTS     = 1 << LOG2_N;
    localparam int  NSEL     = 1 << $clog2(LOG2_N);
    localparam int  CW       = COEF_FRAC + 2;
    localparam int  CB       = twg_pkg::CORR_W;
    localparam real SIN_AMP  = real'((1 << (SIN_W - 1)) - 1);
    localparam real COS_AMP  = real'(1 << (COS_W - 2));
    localparam real COEF_AMP = real'(1 << COEF_FRAC);

    logic signed [CW-1:0]    coef_tab  [NSEL];
    logic signed [SIN_W-1:0] sinit_tab [NSEL];
    logic signed [COS_W-1:0] cinit_tab [NSEL];
    logic [CB-1:0]           slsb_tab  [NPTS];
    logic [CB-1:0]           clsb_tab  [NPTS];

    // Per angle code: cos(theta) coefficient and the n = -1 initial samples.
    for (genvar g = 0; g < NSEL; g++) begin : g_sel
        localparam int KP = 1 << twg_pkg::clamp_sel(g, LOG2_N);
        localparam int CV = twg_pkg::q_wave(KP, LOG2_N, COEF_AMP, 1'b1);
        localparam int SV = -twg_pkg::q_wave(KP, LOG2_N, SIN_AMP, 1'b0);
        localparam int CI = twg_pkg::q_wave(KP, LOG2_N, COS_AMP, 1'b1);
        assign coef_tab[g]  = CW'(CV);
        assign sinit_tab[g] = SIN_W'(SV);
        assign cinit_tab[g] = COS_W'(CI);
    end

    // Per phase position: the low bits of the exactly rounded samples.
    for (genvar i = 0; i < NPTS; i++) begin : g_phase
        localparam int SL = twg_pkg::q_wave(i, LOG2_N, SIN_AMP, 1'b0);
        localparam int CL = twg_pkg::q_wave(i, LOG2_N, COS_AMP, 1'b1);
        assign slsb_tab[i] = CB'(SL);
        assign clsb_tab[i] = CB'(CL);
    end

    assign coef     = coef_tab[run_sel];
    assign sin_init = sinit_tab[load_sel];
    assign cos_init = cinit_tab[load_sel];
    assign sin_lsb  = slsb_tab[lsb_idx];
    assign cos_lsb  = clsb_tab[lsb_idx];

endmodule

// File: rtl/twg_lane.sv
module twg_lane #(
    parameter int W         = 16,
    parameter int COEF_FRAC = 24
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           chk_en,
    input  logic signed [W-1:0]            prev1,
    input  logic signed [W-1:0]            prev2,
    input  logic signed [COEF_FRAC+1:0]    coef,
    input  logic [twg_pkg::CORR_W-1:0]     lsb_ref,
    output logic signed [W-1:0]            next
);
    localparam int CW = COEF_FRAC + 2;
    localparam int PW = W + CW;
    localparam int CB = twg_pkg::CORR_W;
    localparam logic signed [PW-1:0] RND = PW'(1) <<< (COEF_FRAC - 2);

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] scaled;
    logic signed [W:0]    raw;
    logic [CB-1:0]        fix;
    logic signed [W:0]    corr;

    always_comb begin
        prod   = prev1 * coef;
        // 2*cos*x(n-1) with round-half-up at the coefficient's fraction point
        scaled = (prod + RND) >>> (COEF_FRAC - 1);
        raw    = scaled[W:0] - {prev2[W-1], prev2};
        // difference of low bits, exact minus computed, taken modulo 2^CB
        fix    = lsb_ref - raw[CB-1:0];
        corr   = raw + {{(W + 1 - CB){fix[CB-1]}}, fix};
        next   = corr[W-1:0];
    end

    // R6: raw error must stay inside the window the low-bit fix can repair
    a_r6_corr_window: assert property (@(posedge clk) disable iff (rst)
        chk_en |-> (fix != {1'b1, {(CB - 1){1'b0}}}));

    // R4: scaled product and corrected sample fit their intermediate widths
    a_r4_lane_fits: assert property (@(posedge clk) disable iff (rst)
        chk_en |-> (((scaled[PW-1:W] == '0) || (scaled[PW-1:W] == '1))
                    && (corr[W] == corr[W-1])));

endmodule

// File: rtl/twg_round.sv
module twg_round #(
    parameter int IN_W  = 23,
    parameter int OUT_W = 16
) (
    input  logic signed [IN_W-1:0]  din,
    output logic signed [OUT_W-1:0] dout
);
    localparam int DROP = IN_W - 1 - OUT_W;
    localparam logic signed [IN_W:0] HALF = (IN_W + 1)'(1) <<< (DROP - 1);
    localparam logic signed [IN_W:0] MAXV = (IN_W + 1)'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [IN_W:0] MINV = -(IN_W + 1)'(1 << (OUT_W - 1));

    logic signed [IN_W:0] sum;
    logic signed [IN_W:0] sh;

    always_comb begin
        sum = {din[IN_W-1], din} + HALF;
        sh  = sum >>> DROP;
        if (sh > MAXV)      dout = MAXV[OUT_W-1:0];
        else if (sh < MINV) dout = MINV[OUT_W-1:0];
        else                dout = sh[OUT_W-1:0];
    end

endmodule

// File: rtl/twiddle_osc.sv
module twiddle_osc #(
    parameter int LOG2_N    = 6,
    parameter int SIN_W     = 16,
    parameter int COS_W     = 23,
    parameter int OUT_W     = 16,
    parameter int COEF_FRAC = 24
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic [$clog2(LOG2_N)-1:0]     angle_sel,
    input  logic                          step,
    output logic signed [SIN_W-1:0]       sin_out,
    output logic signed [OUT_W-1:0]       cos_out,
    output logic                          valid
);
    import twg_pkg::*;

    localparam int  SW      = $clog2(LOG2_N);
    localparam int  CW      = COEF_FRAC + 2;
    localparam int  DROP    = COS_W - 1 - OUT_W;
    localparam real SIN_AMP = real'((1 << (SIN_W - 1)) - 1);
    localparam real COS_AMP = real'(1 << (COS_W - 2));
    localparam logic signed [COS_W-1:0] COS_ONE  = COS_W'(1 << (COS_W - 2));
    localparam logic signed [SIN_W-1:0] RST_S2   = SIN_W'(-q_wave(1, LOG2_N, SIN_AMP, 1'b0));
    localparam logic signed [COS_W-1:0] RST_C2   = COS_W'(q_wave(1, LOG2_N, COS_AMP, 1'b1));
    localparam logic signed [COS_W-1:0] SAT_EDGE = COS_ONE - COS_W'(1 << (DROP - 1));
    localparam logic signed [OUT_W-1:0] OUT_MAX  = OUT_W'((1 << (OUT_W - 1)) - 1);

    twg_op_e                 op;
    logic [SW-1:0]           sel_c;
    logic [SW-1:0]           sel_r;
    logic [LOG2_N-1:0]       phase;
    logic [LOG2_N-1:0]       kstep;
    logic [LOG2_N-1:0]       nidx;
    logic signed [SIN_W-1:0] s_p1, s_p2, s_nx;
    logic signed [COS_W-1:0] c_p1, c_p2, c_nx;
    logic signed [OUT_W-1:0] c_rnd;
    logic signed [CW-1:0]    coef;
    logic signed [SIN_W-1:0] sin_init;
    logic signed [COS_W-1:0] cos_init;
    logic [CORR_W-1:0]       sin_lsb, cos_lsb;
    logic                    adv;

    always_comb begin
        if (start)     op = OP_LOAD;
        else if (step) op = OP_ADV;
        else           op = OP_HOLD;
        adv   = (op == OP_ADV);
        sel_c = (angle_sel > SW'(LOG2_N - 1)) ? SW'(LOG2_N - 1) : angle_sel;
        kstep = LOG2_N'(1) << sel_r;
        nidx  = phase + kstep;
    end

    twg_rom #(.LOG2_N(LOG2_N), .SIN_W(SIN_W), .COS_W(COS_W), .COEF_FRAC(COEF_FRAC)) u_rom (
        .load_sel (sel_c),
        .run_sel  (sel_r),
        .lsb_idx  (nidx),
        .coef     (coef),
        .sin_init (sin_init),
        .cos_init (cos_init),
        .sin_lsb  (sin_lsb),
        .cos_lsb  (cos_lsb)
    );

    twg_lane #(.W(SIN_W), .COEF_FRAC(COEF_FRAC)) u_sin (
        .clk(clk), .rst(rst), .chk_en(adv),
        .prev1(s_p1), .prev2(s_p2), .coef(coef), .lsb_ref(sin_lsb), .next(s_nx)
    );

    twg_lane #(.W(COS_W), .COEF_FRAC(COEF_FRAC)) u_cos (
        .clk(clk), .rst(rst), .chk_en(adv),
        .prev1(c_p1), .prev2(c_p2), .coef(coef), .lsb_ref(cos_lsb), .next(c_nx)
    );

    twg_round #(.IN_W(COS_W), .OUT_W(OUT_W)) u_rnd (
        .din  (c_nx),
        .dout (c_rnd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_r   <= '0;
            phase   <= '0;
            s_p1    <= '0;
            s_p2    <= RST_S2;
            c_p1    <= COS_ONE;
            c_p2    <= RST_C2;
            sin_out <= '0;
            cos_out <= '0;
            valid   <= 1'b0;
        end else begin
            unique case (op)
                OP_LOAD: begin
                    sel_r <= sel_c;
                    phase <= '0;
                    s_p1  <= '0;
                    s_p2  <= sin_init;
                    c_p1  <= COS_ONE;
                    c_p2  <= cos_init;
                    valid <= 1'b0;
                end
                OP_ADV: begin
                    phase   <= nidx;
                    s_p2    <= s_p1;
                    s_p1    <= s_nx;
                    c_p2    <= c_p1;
                    c_p1    <= c_nx;
                    sin_out <= s_nx;
                    cos_out <= c_rnd;
                    valid   <= 1'b1;
                end
                default: valid <= 1'b0;
            endcase
        end
    end

    // R3: an accepted step is flagged one cycle later
    a_r3_valid_follows_step: assert property (@(posedge clk) disable iff (rst)
        (step && !start) |=> valid);

    // R3, R7: no valid without an accepted step
    a_r3_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !(step && !start) |=> !valid);

    // R8: outputs hold when no step is accepted
    a_r8_hold_outputs: assert property (@(posedge clk) disable iff (rst)
        !(step && !start) |=> ($stable(sin_out) && $stable(cos_out)));

    // R5: a cosine sample at or above the rounding edge of 1.0 saturates
    a_r5_pos_saturate: assert property (@(posedge clk) disable iff (rst)
        (adv && (c_nx >= SAT_EDGE)) |=> (cos_out == OUT_MAX));

endmodule

// File: tb/sim_twiddle_osc.sv
module sim_twiddle_osc;
    localparam int CLK_PERIOD = 10;
    localparam int LOG2N      = 6;
    localparam int NPTS       = 1 << LOG2N;
    localparam real PI_B      = 3.14159265358979323846;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  angle_sel = 3'd0;
    logic        step = 1'b0;
    logic signed [15:0] sin_out;
    logic signed [15:0] cos_out;
    logic        valid;

    int tests = 0;
    int fails = 0;
    int m_sel = 0;
    int m_n   = 0;
    int last_s = 0;
    int last_c = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    twiddle_osc u0 (
        .clk(clk), .rst(rst), .start(start), .angle_sel(angle_sel),
        .step(step), .sin_out(sin_out), .cos_out(cos_out), .valid(valid)
    );

    function automatic int exp_sin(input int p);
        real a;
        a = 2.0 * PI_B * real'(p) / real'(NPTS);
        return $rtoi($floor(32767.0 * $sin(a) + 0.5));
    endfunction

    function automatic int exp_cos(input int p);
        real a;
        int  c;
        int  r;
        a = 2.0 * PI_B * real'(p) / real'(NPTS);
        c = $rtoi($floor(2097152.0 * $cos(a) + 0.5));
        r = (c + 32) >>> 6;
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_step(input string tag);
        int p;
        int es;
        int ec;
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
        m_n++;
        p  = (m_n * (1 << m_sel)) % NPTS;
        es = exp_sin(p);
        ec = exp_cos(p);
        chk({tag, " R3 valid"}, int'(valid), 1);
        chk({tag, " R4 sin"}, int'(sin_out), es);
        chk({tag, " R5 cos"}, int'(cos_out), ec);
        last_s = es;
        last_c = ec;
    endtask

    task automatic do_start(input int sel, input bit with_step, input string tag);
        start     = 1'b1;
        step      = with_step;
        angle_sel = 3'(sel);
        @(negedge clk);
        start = 1'b0;
        step  = 1'b0;
        m_sel = (sel > LOG2N - 1) ? LOG2N - 1 : sel;
        m_n   = 0;
        chk({tag, " R2 no valid on start"}, int'(valid), 0);
        chk({tag, " R2 sin held"}, int'(sin_out), last_s);
        chk({tag, " R2 cos held"}, int'(cos_out), last_c);
    endtask

    task automatic do_idle(input string tag);
        @(negedge clk);
        chk({tag, " R3 valid low"}, int'(valid), 0);
        chk({tag, " R8 sin held"}, int'(sin_out), last_s);
        chk({tag, " R8 cos held"}, int'(cos_out), last_c);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 valid", int'(valid), 0);
        chk("R1 sin", int'(sin_out), 0);
        chk("R1 cos", int'(cos_out), 0);

        // R9: steps with no prior start use angle code 0
        for (int i = 0; i < 5; i++) do_step("R9");
        do_idle("R9");

        // R2, R4, R5: code 3 is an 8-step circle; sample 4 hits cos=-1, sample 8 hits cos=+1
        do_start(3, 1'b0, "R2 code3");
        do_idle("R2 code3");
        for (int i = 0; i < 10; i++) do_step("R5 code3");

        // R10: out-of-range codes act as theta = pi
        do_start(7, 1'b0, "R10 code7");
        do_step("R10 code7");
        chk("R10 cos at pi", int'(cos_out), -32768);
        do_step("R10 code7");
        chk("R5 cos saturates at +1", int'(cos_out), 32767);
        do_start(6, 1'b0, "R10 code6");
        do_step("R10 code6");

        // R7: start and step together, start wins
        do_start(2, 1'b1, "R7");
        do_idle("R7");
        do_step("R7 first after start");

        // R11: restart in the middle of a sequence
        do_start(1, 1'b0, "R11");
        for (int i = 0; i < 5; i++) do_step("R11 code1");
        do_start(4, 1'b0, "R11 restart");
        do_step("R11 n1 code4");

        // R8: outputs hold over several idle cycles
        for (int i = 0; i < 4; i++) do_idle("R8");

        // R6: long run at the finest angle, many full turns
        do_start(0, 1'b0, "R6");
        for (int i = 0; i < 1500; i++) do_step("R6 long run");

        // random mix of operations
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom_range(0, 9));
            if (r == 0)      do_start(int'($urandom_range(0, 7)), 1'b0, "R2 rnd");
            else if (r == 1) do_idle("R8 rnd");
            else if (r == 2) do_start(int'($urandom_range(0, 7)), 1'b1, "R7 rnd");
            else             do_step("R4 rnd");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule